// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one shift register of recent resolved outcomes that all branches share, and a table of 2-bit saturating counters. A lookup combines the history with the word-address bits of the branch PC by XOR and uses the result as the table index. Two branches that see the same recent history therefore tend to land on different counters. The most significant bit of the selected counter is the prediction.

Lookups arrive on a valid/ready request stream that carries the PC. One cycle after the request is accepted, a registered response holds the taken/not-taken guess and the table index that produced it. The response waits while the consumer holds `pr_ready` low, and the request side stops accepting new lookups while a response is waiting. A request is accepted when `pq_valid` and `pq_ready` are both high at a rising edge. A response is consumed when `pr_valid` and `pr_ready` are both high.

When a branch resolves, the pipeline presents the outcome on the update port together with the index the response returned at prediction time. The update port has no back-pressure and is taken on every cycle where `up_valid` is high. That counter is trained, and the outcome is shifted into the history. A lookup accepted in the same cycle as an update sees the table and history as they were before that update.

Top module: `gshare_predictor`

## Requirements
- R1: After reset the history is all zeros, every counter holds 01, `pr_valid` is 0 and `pq_ready` is 1, so the first lookup predicts not-taken.
- R2: The response index equals the history XOR PC bits [K+1:2], using the history at the acceptance edge, with K = 10 by default.
- R3: `pr_taken` is bit 1 of the counter at the response index, read at the acceptance edge. Counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken.
- R4: A taken update adds one to the counter at `up_index`, and a counter at 11 stays at 11.
- R5: A not-taken update subtracts one from the counter at `up_index`, and a counter at 00 stays at 00.
- R6: Every update shifts the history left by one bit and places the outcome in bit 0, where 1 means taken.
- R7: Training touches only the entry named by `up_index`. It does not use an index derived from the current history or PC.
- R8: While `pr_valid` is 1 and `pr_ready` is 0, the response stays valid with its payload unchanged and `pq_ready` is 0. Otherwise `pq_ready` is 1.
- R9: A lookup accepted in the same cycle as an update to the same entry returns the counter value from before that update.
- R10: A cycle with `up_valid` low changes neither the history nor any counter, whatever `up_taken` and `up_index` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pq_valid | input | 1 | Lookup request valid |
| pq_ready | output | 1 | Lookup request can be accepted |
| pq_pc | input | PC_W | Branch PC for the lookup |
| pr_valid | output | 1 | Response valid |
| pr_ready | input | 1 | Consumer takes the response |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| pr_index | output | K | Table index used for this prediction |
| up_valid | input | 1 | Resolved outcome present |
| up_taken | input | 1 | Resolved direction, 1 = taken |
| up_index | input | K | Index returned when the branch was predicted |

## Verification
Counter saturation at both ends is hard to reach from the ports. Each update also moves the history, so a fixed PC keeps landing on a different entry. The bench tracks the history and picks the PC as the history XOR the wanted index, shifted to the word position. This lets it read the entry it just trained. It also places a lookup and an update on one entry in the same cycle to reach the read-before-write case. The bench then holds the response under back-pressure while updates keep arriving.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_e;

  localparam logic [1:0] CTR_RESET = CTR_WEAK_NT;

  // Saturating step of a 2-bit counter toward the given direction.
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    logic [1:0] n;
    if (taken) n = (c == CTR_STRONG_T) ? c : c + 2'd1;
    else       n = (c == CTR_STRONG_NT) ? c : c - 2'd1;
    return n;
  endfunction

endpackage

// File: rtl/gshare_hist.sv
module gshare_hist #(
  parameter int K = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_bit,
  output logic [K-1:0] hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[K-2:0], shift_bit};
  end
endmodule

// File: rtl/gshare_pht.sv
module gshare_pht #(
  parameter int K = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [K-1:0] rd_idx,
  output logic [1:0]   rd_ctr,
  input  logic         wr_en,
  input  logic [K-1:0] wr_idx,
  input  logic         wr_taken
);
  import gshare_pkg::*;
  localparam int ENTRIES = 1 << K;

  logic [1:0] ctr [ENTRIES];

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ctr[g] <= CTR_RESET;
        else if (wr_en && (wr_idx == K'(g)))
          ctr[g] <= ctr_step(ctr[g], wr_taken);
      end
    end
  endgenerate

  assign rd_ctr = ctr[rd_idx];
endmodule

// File: rtl/gshare_resp.sv
module gshare_resp #(
  parameter int K = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_taken,
  input  logic [K-1:0] in_index,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_taken,
  output logic [K-1:0] out_index
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_taken <= 1'b0;
      out_index <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken <= in_taken;
        out_index <= in_index;
      end
    end
  end
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
  parameter int K    = 10,
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pq_valid,
  output logic            pq_ready,
  input  logic [PC_W-1:0] pq_pc,
  output logic            pr_valid,
  input  logic            pr_ready,
  output logic            pr_taken,
  output logic [K-1:0]    pr_index,
  input  logic            up_valid,
  input  logic            up_taken,
  input  logic [K-1:0]    up_index
);
  localparam int PC_LO = 2;
  localparam int PC_HI = K + PC_LO - 1;

  logic [K-1:0] ghr;
  logic [K-1:0] lookup_idx;
  logic [1:0]   lookup_ctr;

  assign lookup_idx = ghr ^ pq_pc[PC_HI:PC_LO];

  gshare_hist #(.K(K)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(up_valid), .shift_bit(up_taken),
    .hist(ghr)
  );

  gshare_pht #(.K(K)) u_pht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lookup_idx), .rd_ctr(lookup_ctr),
    .wr_en(up_valid), .wr_idx(up_index), .wr_taken(up_taken)
  );

  gshare_resp #(.K(K)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pq_valid), .in_ready(pq_ready),
    .in_taken(lookup_ctr[1]), .in_index(lookup_idx),
    .out_valid(pr_valid), .out_ready(pr_ready),
    .out_taken(pr_taken), .out_index(pr_index)
  );
endmodule

// File: rtl/gshare_checker.sv
module gshare_checker #(
  parameter int K    = 10,
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pq_valid,
  input logic            pq_ready,
  input logic [PC_W-1:0] pq_pc,
  input logic            pr_valid,
  input logic            pr_ready,
  input logic            pr_taken,
  input logic [K-1:0]    pr_index,
  input logic            up_valid,
  input logic            up_taken,
  input logic [K-1:0]    ghr
);
  // R8
  hold_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && !pr_ready |=> pr_valid && $stable(pr_index) && $stable(pr_taken));

  // R8
  stall_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && !pr_ready |-> !pq_ready);

  // R2
  resp_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pq_valid && pq_ready |=> pr_valid && (pr_index == $past(ghr ^ pq_pc[K+1:2])));

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghr == {$past(ghr[K-2:0]), $past(up_taken)});

  // R10
  hist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghr));
endmodule

bind gshare_predictor gshare_checker #(.K(K), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .pq_valid(pq_valid), .pq_ready(pq_ready), .pq_pc(pq_pc),
  .pr_valid(pr_valid), .pr_ready(pr_ready),
  .pr_taken(pr_taken), .pr_index(pr_index),
  .up_valid(up_valid), .up_taken(up_taken), .ghr(ghr)
);

// File: tb/sim_gshare_predictor.sv
module sim_gshare_predictor;
  localparam int K       = 10;
  localparam int PC_W    = 32;
  localparam int ENT     = 1 << K;
  localparam int CLK_PER = 10;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            pq_valid = 0, pr_ready = 1, up_valid = 0, up_taken = 0;
  logic [PC_W-1:0] pq_pc = '0;
  logic [K-1:0]    up_index = '0;
  logic            pq_ready, pr_valid, pr_taken;
  logic [K-1:0]    pr_index;

  gshare_predictor #(.K(K), .PC_W(PC_W)) u0 (.*);

  always #(CLK_PER/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [1:0]   mdl [ENT];
  logic [K-1:0] mhist;
  bit           ev;
  logic         et;
  logic [K-1:0] ei;
  logic [K-1:0] last_idx;

  function automatic logic [1:0] step_ctr(logic [1:0] c, logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic logic [PC_W-1:0] pc_for(logic [K-1:0] idx);
    return PC_W'(mhist ^ idx) << 2;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, predict, step model, compare at next negedge.
  task automatic step(bit pqv, logic [PC_W-1:0] pc, bit prr,
                      bit upv, bit upt, logic [K-1:0] upi, string tag);
    bit rdy;
    logic [K-1:0] idx;
    pq_valid = pqv; pq_pc = pc; pr_ready = prr;
    up_valid = upv; up_taken = upt; up_index = upi;
    #1;
    rdy = !ev || prr;
    chk("R8 pq_ready", pq_ready, rdy);
    idx = mhist ^ pc[K+1:2];
    if (rdy) begin
      if (pqv) begin ev = 1; et = mdl[idx][1]; ei = idx; last_idx = idx; end
      else ev = 0;
    end
    if (upv) begin
      mdl[upi] = step_ctr(mdl[upi], upt);
      mhist = {mhist[K-2:0], upt};
    end
    @(posedge clk); @(negedge clk);
    chk({tag, " valid"}, pr_valid, ev);
    if (ev) begin
      chk({"R2 index ", tag}, pr_index, ei);
      chk({"R3 taken ", tag}, pr_taken, et);
    end
  endtask

  task automatic idle(); step(0, '0, 1, 0, 0, '0, "idle"); endtask

  // Read the counter at idx through a lookup and compare its direction.
  task automatic probe(logic [K-1:0] idx, logic exp_t, string tag);
    step(1, pc_for(idx), 1, 0, 0, '0, tag);
    chk(tag, pr_taken, exp_t);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < ENT; i++) mdl[i] = 2'b01;
    mhist = '0; ev = 0; et = 0; ei = '0; last_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pr_valid", pr_valid, 0);
    chk("R1 pq_ready", pq_ready, 1);
    probe(10'h000, 0, "R1 first lookup");

    // R4 saturate high on entry 5
    for (int i = 0; i < 4; i++) step(0, '0, 1, 1, 1, 10'd5, "R4 train");
    probe(10'd5, 1, "R4 taken after training");
    step(0, '0, 1, 1, 0, 10'd5, "R4 dec");
    probe(10'd5, 1, "R4 saturated at 11");
    step(0, '0, 1, 1, 0, 10'd5, "R4 dec2");
    probe(10'd5, 0, "R4 back to weak nt");

    // R5 saturate low on entry 9
    for (int i = 0; i < 3; i++) step(0, '0, 1, 1, 0, 10'd9, "R5 train");
    step(0, '0, 1, 1, 1, 10'd9, "R5 inc");
    probe(10'd9, 0, "R5 saturated at 00");
    step(0, '0, 1, 1, 1, 10'd9, "R5 inc2");
    probe(10'd9, 1, "R5 reached 10");

    // R6 history visible through pc=0 lookup
    step(0, '0, 1, 1, 1, 10'd100, "R6 upd");
    step(1, '0, 1, 0, 0, '0, "R6 hist");
    chk("R6 history", pr_index, mhist);

    // R7 trained index differs from current history index
    step(0, '0, 1, 1, 1, 10'd700, "R7 upd");
    step(0, '0, 1, 1, 1, 10'd700, "R7 upd2");
    probe(10'd700, 1, "R7 entry 700 trained");
    probe(mhist ^ 10'd1, 0, "R7 neighbour untouched");

    // R9 same-cycle lookup and update, entry 33 at 01 -> 10
    step(1, pc_for(10'd33), 1, 1, 1, 10'd33, "R9");
    chk("R9 old value", pr_taken, 0);
    probe(10'd33, 1, "R9 new value");

    // R10 idle update pins
    step(0, '0, 1, 0, 1, 10'd44, "R10 idle");
    step(0, '0, 1, 0, 1, 10'd44, "R10 idle2");
    probe(10'd44, 0, "R10 counter untouched");
    step(1, '0, 1, 0, 1, 10'd44, "R10 hist");
    chk("R10 history", pr_index, mhist);

    // R8 back-pressure with updates underneath
    step(1, pc_for(10'd5), 0, 0, 0, '0, "R8 load");
    step(1, 32'h40, 0, 1, 1, 10'd3, "R8 hold");
    step(1, 32'h80, 0, 1, 0, 10'd4, "R8 hold2");
    chk("R8 held index", pr_index, ei);
    step(0, '0, 1, 0, 0, '0, "R8 drain");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [K-1:0] ui;
      ui = ($urandom % 2) ? last_idx : K'($urandom);
      step($urandom % 4 != 0, $urandom, $urandom % 5 != 0,
           $urandom % 2, $urandom % 3 != 0, ui, "rand");
    end
    idle();

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule